// File: doc/BRIEF.md
# Multiprocessor Limit Timer Bank

This block holds a set of down-counting interval timers for a multiprocessor system. Each processor has a private timer that drives only that processor's level-14 interrupt line. One master timer drives the level-10 line of every processor at once. All timers share one tick-enable input, which comes from a prescaler outside the block. On each tick every timer decrements. When a timer's count would reach zero, it sets a sticky limit-reached flag and reloads from its limit in the same cycle. The flag holds the interrupt line high until software acknowledges it.

Software reaches the timers through a flat register port. Each timer owns four words: a limit word, a count word, a second limit word that does not acknowledge, and a control word. Reading the limit word returns the value and acknowledges the flag. The second limit word lets software retune the period without losing a pending event. In the limit and count words, the top bit is the flag and bits 30:10 carry the 21-bit value.

Top module: `mp_limit_timers`

## Requirements
- R1: The address is {timer index, word}, with the word in the two low bits. Indices 0..NCPU-1 select the per-processor timers and index NCPU selects the master timer. Word 0 is the acknowledging limit, word 1 the count, word 2 the non-acknowledging limit and word 3 the control word. In the limit and count words, bit 31 is the flag, bits 30:10 are the value and bits 9:0 read 0. A read of any other index returns 0, and a write to any other index changes nothing.
- R2: After reset, every limit and count value is 10000 (word 0x009C4000), every flag is clear, every interrupt is low, each per-processor control word reads 1 and the master control word reads 0.
- R3: Each tick decrements the count. When the decremented count would be zero, the flag is set and the count reloads from the limit in that same cycle. A nonzero limit L therefore gives a period of L ticks.
- R4: A limit of zero makes the counter wrap to 0x1FFFFF and run through the whole 21-bit range, so the period is 2^21 ticks.
- R5: Reading word 0 returns the flag and limit as they were before the read, then clears the flag. If the same cycle also holds a tick that ends the period, the flag stays set.
- R6: Writing word 0 loads the limit and the count from bits 30:10 and clears the flag. This write takes precedence over a period-ending tick in the same cycle. Bits 31 and 9:0 of the written data are ignored.
- R7: Writing word 2 changes only the limit. The count and the flag keep their values, and the new limit takes effect at the next reload.
- R8: Writes to word 1 are ignored. Reading word 1 or word 2 does not clear the flag.
- R9: Bit i of irq_l14 equals the flag of per-processor timer i. Every bit of irq_l10 equals the master flag.
- R10: Word 3 is a 32-bit read/write storage word for each timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable pulse from the prescaler |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | $clog2(NCPU+1)+2 | {timer index, word} |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one cycle after rd_en |
| irq_l14 | output | NCPU | Per-processor level-14 requests |
| irq_l10 | output | NCPU | Master level-10 request, copied to each processor |

## Verification
Two functions can fall in the same cycle: a software access to the limit word, and the tick that ends a period. The bench provokes this by asserting tick in the same cycle as a word-0 read or write, with the count at 1. A read must return the flag as it was before the read, and the flag must still be set afterwards. A write must leave the flag clear and the new value in the count.

The remaining checks sweep every timer of a two-processor configuration through several limits. The expected counts are computed as L minus the ticks applied, and the expected reload points as multiples of L.

// File: rtl/mp_limit_timers.sv
module mp_limit_timers #(
  parameter int          NCPU        = 4,
  parameter logic [20:0] CPU_INIT    = 21'd10000,
  parameter logic [20:0] MASTER_INIT = 21'd10000,
  localparam int NT = NCPU + 1,
  localparam int IW = $clog2(NT),
  localparam int AW = IW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [NCPU-1:0] irq_l14,
  output logic [NCPU-1:0] irq_l10
);
  localparam int VW = 21;
  localparam int VLO = 10;

  logic [IW-1:0]        sel;
  logic [1:0]           word;
  logic                 hit;
  logic [VW-1:0]        wval;
  logic [NT-1:0][VW-1:0] lim_a, cnt_a;
  logic [NT-1:0][31:0]  ctl_a;
  logic [NT-1:0]        flag_a;
  logic [31:0]          rmux;

  assign sel  = addr[AW-1:2];
  assign word = addr[1:0];
  assign hit  = int'(sel) < NT;
  assign wval = wdata[VLO+VW-1:VLO];

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic [VW-1:0] lim_q, cnt_q, dec;
    logic [31:0]   ctl_q;
    logic          flag_q, me, term;

    assign me   = (sel == IW'(t));
    assign dec  = cnt_q - 1'b1;
    assign term = tick && (dec == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lim_q  <= (t < NCPU) ? CPU_INIT : MASTER_INIT;
        cnt_q  <= (t < NCPU) ? CPU_INIT : MASTER_INIT;
        flag_q <= 1'b0;
        ctl_q  <= (t < NCPU) ? 32'd1 : 32'd0;
      end else begin
        if (wr_en && me && word == 2'd0) begin
          lim_q  <= wval;
          cnt_q  <= wval;
          flag_q <= 1'b0;
        end else begin
          if (wr_en && me && word == 2'd2) lim_q <= wval;
          if (tick) cnt_q <= term ? lim_q : dec;
          if (term) flag_q <= 1'b1;
          else if (rd_en && me && word == 2'd0) flag_q <= 1'b0;
        end
        if (wr_en && me && word == 2'd3) ctl_q <= wdata;
      end
    end

    assign lim_a[t]  = lim_q;
    assign cnt_a[t]  = cnt_q;
    assign ctl_a[t]  = ctl_q;
    assign flag_a[t] = flag_q;
  end

  always_comb begin
    rmux = '0;
    if (hit) begin
      case (word)
        2'd1:    rmux = {flag_a[sel], cnt_a[sel], {VLO{1'b0}}};
        2'd3:    rmux = ctl_a[sel];
        default: rmux = {flag_a[sel], lim_a[sel], {VLO{1'b0}}};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rmux;
  end

  assign irq_l14 = flag_a[NCPU-1:0];
  assign irq_l10 = {NCPU{flag_a[NCPU]}};
endmodule

module mp_limit_timers_chk #(
  parameter int NCPU = 4,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            rd_en,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [NCPU-1:0] irq_l14,
  input logic [NCPU-1:0] irq_l10
);
  localparam logic [AW-1:0] A_T0_LIM = '0;
  localparam logic [AW-1:0] A_T0_NC  = AW'(2);

  p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_l14[0]) |-> $past(tick));

  p_l10_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_l10[0]) |-> $past(tick));

  p_read_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == A_T0_LIM && !tick |=> !irq_l14[0]);

  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_T0_LIM |=> !irq_l14[0]);

  p_noclear_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_T0_NC && !rd_en && !tick |=> $stable(irq_l14[0]));

  p_quiet_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !rd_en && !wr_en |=> $stable(irq_l14) && $stable(irq_l10));

  p_l10_uniform_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_l10) == 0 || $countones(irq_l10) == NCPU);
endmodule

bind mp_limit_timers mp_limit_timers_chk #(.NCPU(NCPU), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .irq_l14(irq_l14), .irq_l10(irq_l10)
);

// File: tb/sim_mp_limit_timers.sv
module sim_mp_limit_timers;
  localparam int NCPU = 2;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NCPU-1:0] irq_l14, irq_l10;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mp_limit_timers #(.NCPU(NCPU)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_l14(irq_l14), .irq_l10(irq_l10)
  );

  function automatic logic [31:0] fv(input logic f, input logic [20:0] v);
    return {f, v, 10'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic r, input logic w, input logic tk,
                     input int idx, input int wd, input logic [31:0] d);
    @(negedge clk);
    rd_en = r; wr_en = w; tick = tk;
    addr = {idx[1:0], wd[1:0]}; wdata = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input int idx, input int wd);
    acc(1'b1, 1'b0, 1'b0, idx, wd, 32'h0);
  endtask

  task automatic wr(input int idx, input int wd, input logic [31:0] d);
    acc(1'b0, 1'b1, 1'b0, idx, wd, d);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  function automatic logic irq_of(input int t);
    return (t < NCPU) ? irq_l14[t] : (irq_l10 == 2'b11);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int lims[5] = '{1, 2, 3, 5, 8};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    chk("R2 irq", {28'h0, irq_l14, irq_l10}, 32'h0);
    for (int t = 0; t <= NCPU; t++) begin
      rd(t, 0); chk("R2 limit", rdata, 32'h009C4000);
      rd(t, 1); chk("R2 count", rdata, 32'h009C4000);
      rd(t, 3); chk("R2 control", rdata, (t < NCPU) ? 32'd1 : 32'd0);
    end

    // R3 sweep over all timers and several limits
    for (int t = 0; t <= NCPU; t++) begin
      for (int i = 0; i < 5; i++) begin
        int L = lims[i];
        wr(t, 0, fv(1'b0, 21'(L)));
        for (int k = 1; k < L; k++) begin
          ticks(1);
          rd(t, 1); chk("R3 count", rdata, fv(1'b0, 21'(L - k)));
        end
        ticks(1);
        chk("R3 flag set at period end", {31'h0, irq_of(t)}, 32'h1);
        rd(t, 1); chk("R3 reload R8 count read keeps flag", rdata, fv(1'b1, 21'(L)));
        rd(t, 2); chk("R8 nc read keeps flag", rdata, fv(1'b1, 21'(L)));
        rd(t, 0); chk("R5 ack read value", rdata, fv(1'b1, 21'(L)));
        chk("R5 ack clears irq", {31'h0, irq_of(t)}, 32'h0);
        rd(t, 0); chk("R5 flag cleared", rdata, fv(1'b0, 21'(L)));
      end
    end

    // R4 zero limit wraps through full range
    wr(1, 0, 32'h0);
    ticks(1);
    rd(1, 1); chk("R4 wrap", rdata, 32'h7FFFFC00);
    ticks(2);
    rd(1, 1); chk("R4 full range count", rdata, fv(1'b0, 21'h1FFFFD));

    // R5 read-ack concurrent with period-ending tick
    wr(0, 0, fv(1'b0, 21'd3));
    ticks(2);
    acc(1'b1, 1'b0, 1'b1, 0, 0, 32'h0);
    chk("R5 concurrent read returns pre-value", rdata, fv(1'b0, 21'd3));
    chk("R5 concurrent tick set wins", {31'h0, irq_l14[0]}, 32'h1);
    ticks(2);
    acc(1'b1, 1'b0, 1'b1, 0, 0, 32'h0);
    chk("R5 concurrent with flag already set", rdata, fv(1'b1, 21'd3));
    chk("R5 flag stays set", {31'h0, irq_l14[0]}, 32'h1);
    rd(0, 0); chk("R5 later ack", rdata, fv(1'b1, 21'd3));

    // R6 write concurrent with period-ending tick, stray bits ignored
    wr(0, 0, fv(1'b0, 21'd3));
    ticks(2);
    acc(1'b0, 1'b1, 1'b1, 0, 0, 32'h8000_03FF | fv(1'b0, 21'd6));
    chk("R6 write beats tick", {31'h0, irq_l14[0]}, 32'h0);
    rd(0, 1); chk("R6 count loaded R1 low bits zero", rdata, fv(1'b0, 21'd6));
    rd(0, 2); chk("R6 limit loaded", rdata, fv(1'b0, 21'd6));

    // R7 no-clear limit write
    wr(1, 0, fv(1'b0, 21'd2));
    ticks(2);
    wr(1, 2, fv(1'b0, 21'd5));
    chk("R7 flag kept", {31'h0, irq_l14[1]}, 32'h1);
    rd(1, 1); chk("R7 count kept", rdata, fv(1'b1, 21'd2));
    ticks(2);
    rd(1, 1); chk("R7 new limit at reload", rdata, fv(1'b1, 21'd5));
    rd(1, 0); chk("R7 ack", rdata, fv(1'b1, 21'd5));
    ticks(4);
    chk("R7 no early flag", {31'h0, irq_l14[1]}, 32'h0);
    ticks(1);
    chk("R7 period of new limit", {31'h0, irq_l14[1]}, 32'h1);

    // R8 count word is read-only
    wr(0, 0, fv(1'b0, 21'd9));
    wr(0, 1, 32'hFFFF_FFFF);
    rd(0, 1); chk("R8 count write ignored", rdata, fv(1'b0, 21'd9));

    // R9 interrupt routing
    for (int t = 0; t <= NCPU; t++) wr(t, 0, fv(1'b0, 21'd1000));
    wr(NCPU, 0, fv(1'b0, 21'd2));
    ticks(2);
    chk("R9 master to all", {30'h0, irq_l10}, 32'h3);
    chk("R9 no local irq", {30'h0, irq_l14}, 32'h0);
    rd(NCPU, 0);
    chk("R9 master ack", {30'h0, irq_l10}, 32'h0);
    wr(1, 0, fv(1'b0, 21'd1));
    ticks(1);
    chk("R9 local only", {30'h0, irq_l14}, 32'h2);
    chk("R9 master quiet", {30'h0, irq_l10}, 32'h0);

    // R10 control storage
    wr(1, 3, 32'hDEADBEEF);
    rd(1, 3); chk("R10 cpu control", rdata, 32'hDEADBEEF);
    wr(NCPU, 3, 32'h12345678);
    rd(NCPU, 3); chk("R10 master control", rdata, 32'h12345678);
    rd(0, 3); chk("R10 other untouched", rdata, 32'd1);

    // R1 unmapped index
    rd(3, 0); chk("R1 unmapped read", rdata, 32'h0);
    wr(3, 0, fv(1'b0, 21'd77));
    wr(3, 2, fv(1'b0, 21'd77));
    rd(0, 2); chk("R1 unmapped write no effect", rdata & 32'h7FFFFC00, fv(1'b0, 21'd1000));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule